// File: doc/BRIEF.md
# Result Bus Slot Scheduler

This block hands out future time slots on one shared result bus. An instruction knows its execution latency when it issues. It books the bus cycle in which its result will appear. If that cycle is already booked, it is held back at issue. Because every booking is settled before execution starts, no two functional units ever finish onto the bus in the same cycle, and no arbitration is needed when results arrive.

The booking store is a chain of slots numbered 1 up to the longest latency, `MAX_LAT`. Each slot holds three things:

- an occupied flag
- the identifier of the unit that will drive the bus
- the reorder-buffer tag where the result must land

On every clock edge each booking moves one slot closer to slot 1. The booking that leaves slot 1 is captured in a grant register. During the next cycle that register names the unit that owns the bus and the tag its result is steered to.

A request of latency i is tested against slot i+1 as it is now. That is the content slot i will hold after the same edge, so a booking that is leaving slot i at that edge does not block the request.

A flush input discards every pending booking whose tag is younger than a given tag. Age is measured from the current reorder-buffer head.

Issue uses a valid/ready handshake. A request is taken on a cycle where `iss_valid` and `iss_ready` are both high. `iss_ready` is computed combinationally from the offered latency, the slot contents and the flush input, and it does not depend on `iss_valid`. A producer that sees ready low may hold its request or replace it on the next cycle. Flush and head are plain control pins.

Top module: `rbus_slot_sched`

## Requirements
- R1: `iss_ready` is high exactly when all of the following hold: `iss_lat` is in 1..MAX_LAT, `flush_valid` is low, and either `iss_lat` equals MAX_LAT or slot `iss_lat`+1 is currently unoccupied.
- R2: A request of latency i accepted at clock edge E produces a one-cycle grant in the cycle that begins i edges after E.
- R3: A request whose target slot would still be occupied after the shift is refused. The same request is accepted on a later cycle once that slot is free, and no existing booking is ever overwritten.
- R4: While `gnt_valid` is high, `gnt_unit` and `gnt_tag` equal the unit and tag given with the request that made that booking.
- R5: A latency of 0 or above MAX_LAT is never accepted.
- R6: A latency equal to MAX_LAT is always accepted when no flush is present.
- R7: On a cycle with `flush_valid` high, every booking whose age, (tag − `rob_head`) mod 2^TAG_W, exceeds the age of `flush_tag` produces no grant in any later cycle. Bookings of equal or smaller age are kept. The grant already on the bus in that cycle is not affected.
- R8: `iss_ready` is low while `flush_valid` is high.
- R9: During and straight after reset, no slot is occupied and `gnt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Requested slot can be booked this cycle |
| iss_lat | input | LAT_W | Execution latency of the request, in clocks |
| iss_unit | input | RB_UNIT_W | Functional unit that will produce the result |
| iss_tag | input | RB_TAG_W | Reorder-buffer tag of the destination |
| flush_valid | input | 1 | Discard bookings younger than `flush_tag` |
| flush_tag | input | RB_TAG_W | Youngest tag that survives a flush |
| rob_head | input | RB_TAG_W | Oldest live reorder-buffer tag, the reference point for age |
| gnt_valid | output | 1 | Result bus is owned this cycle |
| gnt_unit | output | RB_UNIT_W | Unit that drives the bus |
| gnt_tag | output | RB_TAG_W | Reorder-buffer entry that receives the result |

## Verification
The bench creates a request whose slot is being vacated by the same edge. A design that tests slot i itself, rather than slot i+1, refuses that request, and its grants then arrive one cycle late. It also creates a request whose slot will still be occupied after the shift. A design without the conflict test overwrites the earlier booking and loses one of the two grants.

Latencies of 0 and MAX_LAT+1 are offered to catch an out-of-range index. A flush is run with tags on both sides of the wrap point, so that a plain numeric compare would discard the wrong bookings. Each grant is also checked for its exact cycle, unit and tag, which exposes any off-by-one in the shift.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  parameter int RB_UNIT_W = 3;
  parameter int RB_TAG_W  = 4;

  typedef struct packed {
    logic                 vld;
    logic [RB_UNIT_W-1:0] unit;
    logic [RB_TAG_W-1:0]  tag;
  } rbus_slot_t;
endpackage

// File: rtl/rbus_age_cmp.sv
module rbus_age_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] head,
  input  logic [W-1:0] ref_tag,
  input  logic [W-1:0] cand_tag,
  output logic         younger
);
  logic [W-1:0] cand_age;
  logic [W-1:0] ref_age;

  // Ages are distances from the head, modulo the tag space.
  always_comb begin
    cand_age = cand_tag - head;
    ref_age  = ref_tag - head;
    younger  = cand_age > ref_age;
  end
endmodule

// File: rtl/rbus_slot.sv
module rbus_slot
  import rbus_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  rbus_slot_t          up,
  input  logic                ins_en,
  input  rbus_slot_t          ins_slot,
  input  logic                kill_en,
  input  logic [RB_TAG_W-1:0] kill_tag,
  input  logic [RB_TAG_W-1:0] head,
  output rbus_slot_t          q
);
  rbus_slot_t nxt;
  rbus_slot_t nxt_k;
  logic       is_young;

  assign nxt = ins_en ? ins_slot : up;

  rbus_age_cmp #(.W(RB_TAG_W)) u_age (
    .head     (head),
    .ref_tag  (kill_tag),
    .cand_tag (nxt.tag),
    .younger  (is_young)
  );

  always_comb begin
    nxt_k = nxt;
    if (kill_en && is_young) nxt_k.vld = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_k;
  end

  // R3: an insertion never lands on a booking that is moving into this slot
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !up.vld);

  // R2: an inserted booking is held here after the edge
  a_r2_insert_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !kill_en) |=> (q.vld && q.tag == $past(ins_slot.tag)
                              && q.unit == $past(ins_slot.unit)));

  // R2: without insertion or flush, the slot takes its upper neighbour
  a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_en && !kill_en) |=> (q == $past(up)));
endmodule

// File: rtl/rbus_slot_sched.sv
module rbus_slot_sched
  import rbus_pkg::*;
#(
  parameter  int MAX_LAT = 8,
  localparam int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  output logic                 iss_ready,
  input  logic [LAT_W-1:0]     iss_lat,
  input  logic [RB_UNIT_W-1:0] iss_unit,
  input  logic [RB_TAG_W-1:0]  iss_tag,
  input  logic                 flush_valid,
  input  logic [RB_TAG_W-1:0]  flush_tag,
  input  logic [RB_TAG_W-1:0]  rob_head,
  output logic                 gnt_valid,
  output logic [RB_UNIT_W-1:0] gnt_unit,
  output logic [RB_TAG_W-1:0]  gnt_tag
);
  // st[0] is the grant register, st[1..MAX_LAT] are the bookings,
  // st[MAX_LAT+1] is a permanently empty source above the top slot.
  rbus_slot_t st [0:MAX_LAT+1];
  rbus_slot_t req;
  logic       lat_ok;
  logic       tgt_busy;
  logic       fire;
  logic [MAX_LAT:1] vld_vec;

  assign st[MAX_LAT+1] = '0;
  assign req = '{vld: 1'b1, unit: iss_unit, tag: iss_tag};
  assign lat_ok = (iss_lat != '0) && (iss_lat <= LAT_W'(MAX_LAT));

  // Slot i after the shift is slot i+1 now.
  always_comb begin
    tgt_busy = 1'b0;
    for (int k = 1; k <= MAX_LAT; k++)
      if (iss_lat == LAT_W'(k)) tgt_busy = st[k+1].vld;
  end

  assign iss_ready = lat_ok && !tgt_busy && !flush_valid;
  assign fire      = iss_valid && iss_ready;

  for (genvar k = 0; k <= MAX_LAT; k++) begin : g_slot
    logic ins_here;
    if (k == 0) begin : g_gnt
      assign ins_here = 1'b0;
    end else begin : g_bk
      assign ins_here = fire && (iss_lat == LAT_W'(k));
      assign vld_vec[k] = st[k].vld;
    end
    rbus_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .up       (st[k+1]),
      .ins_en   (ins_here),
      .ins_slot (req),
      .kill_en  (flush_valid),
      .kill_tag (flush_tag),
      .head     (rob_head),
      .q        (st[k])
    );
  end

  assign gnt_valid = st[0].vld;
  assign gnt_unit  = st[0].unit;
  assign gnt_tag   = st[0].tag;

  // R4: a grant only ever comes from the booking that was in slot 1
  a_r4_grant_from_head: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($past(st[1].vld) && gnt_tag == $past(st[1].tag)
                   && gnt_unit == $past(st[1].unit)));

  // R7: a flush never adds bookings
  a_r7_flush_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> ($countones(vld_vec) <= $countones($past(vld_vec))));

  // R5: an accepted request never names an out-of-range latency
  a_r5_lat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> (iss_lat >= 1 && iss_lat <= LAT_W'(MAX_LAT)));

  // R9: nothing is booked on the first cycle out of reset
  a_r9_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (vld_vec == '0 && !gnt_valid) or rst_n);
endmodule

// File: tb/tb_rbus_slot_sched.sv
module tb_rbus_slot_sched;
  import rbus_pkg::*;
  localparam int MAX_LAT = 8;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [LAT_W-1:0] iss_lat = '0;
  logic [RB_UNIT_W-1:0] iss_unit = '0;
  logic [RB_TAG_W-1:0] iss_tag = '0;
  logic flush_valid = 1'b0;
  logic [RB_TAG_W-1:0] flush_tag = '0;
  logic [RB_TAG_W-1:0] rob_head = '0;
  logic gnt_valid;
  logic [RB_UNIT_W-1:0] gnt_unit;
  logic [RB_TAG_W-1:0] gnt_tag;

  always #5 clk = ~clk;

  rbus_slot_sched #(.MAX_LAT(MAX_LAT)) dut (.*);

  typedef struct packed {
    logic v; logic [3:0] lat; logic [2:0] unit; logic [3:0] tag;
    logic fl; logic [3:0] ftag; logic [3:0] head; logic rdy;
  } vec_t;

  localparam vec_t TBL [18] = '{
    '{1'b1, 4'd3, 3'd1, 4'd1, 1'b0, 4'd0, 4'd1, 1'b1},  // c0 R1 accept
    '{1'b1, 4'd2, 3'd2, 4'd2, 1'b0, 4'd0, 4'd1, 1'b0},  // c1 R3 conflict
    '{1'b1, 4'd2, 3'd2, 4'd2, 1'b0, 4'd0, 4'd1, 1'b1},  // c2 R3 retry ok
    '{1'b1, 4'd1, 3'd3, 4'd3, 1'b0, 4'd0, 4'd1, 1'b0},  // c3 R3 conflict
    '{1'b1, 4'd1, 3'd3, 4'd3, 1'b0, 4'd0, 4'd1, 1'b1},  // c4 R1 vacated slot
    '{1'b1, 4'd8, 3'd4, 4'd4, 1'b0, 4'd0, 4'd1, 1'b1},  // c5 R6 max latency
    '{1'b1, 4'd0, 3'd7, 4'd7, 1'b0, 4'd0, 4'd1, 1'b0},  // c6 R5 zero
    '{1'b1, 4'd9, 3'd7, 4'd7, 1'b0, 4'd0, 4'd1, 1'b0},  // c7 R5 too large
    '{1'b1, 4'd7, 3'd5, 4'd5, 1'b0, 4'd0, 4'd1, 1'b1},  // c8
    '{1'b1, 4'd5, 3'd6, 4'd6, 1'b0, 4'd0, 4'd1, 1'b1},  // c9
    '{1'b1, 4'd2, 3'd7, 4'd7, 1'b1, 4'd5, 4'd1, 1'b0},  // c10 R7 R8 flush
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0},
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0},
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0},
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0},
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0},
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0},
    '{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b0}
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic       mv [256];
  logic [2:0] mu [256];
  logic [3:0] mt [256];

  function automatic bit is_younger(logic [3:0] t, logic [3:0] f, logic [3:0] h);
    logic [3:0] a, b;
    a = t - h;
    b = f - h;
    return a > b;
  endfunction

  task automatic step(vec_t s);
    logic rdy_seen;
    @(negedge clk);
    iss_valid = s.v; iss_lat = s.lat; iss_unit = s.unit; iss_tag = s.tag;
    flush_valid = s.fl; flush_tag = s.ftag; rob_head = s.head;
    #1;
    rdy_seen = iss_ready;
    checks++;
    if (rdy_seen !== s.rdy) begin
      errors++;
      $display("FAIL R1 R3 R5 R6 R8 cycle %0d: iss_ready=%b expected %b", cyc, rdy_seen, s.rdy);
    end
    checks++;
    if (mv[cyc]) begin
      if (gnt_valid !== 1'b1 || gnt_unit !== mu[cyc] || gnt_tag !== mt[cyc]) begin
        errors++;
        $display("FAIL R2 R4 R7 cycle %0d: grant v=%b u=%0d t=%0d expected v=1 u=%0d t=%0d",
                 cyc, gnt_valid, gnt_unit, gnt_tag, mu[cyc], mt[cyc]);
      end
    end else if (gnt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 R7 cycle %0d: grant v=%b expected 0", cyc, gnt_valid);
    end
    @(posedge clk);
    if (s.v && rdy_seen) begin
      mv[cyc + int'(s.lat) + 1] = 1'b1;
      mu[cyc + int'(s.lat) + 1] = s.unit;
      mt[cyc + int'(s.lat) + 1] = s.tag;
    end
    if (s.fl)
      for (int k = cyc + 1; k < 256; k++)
        if (mv[k] && is_younger(mt[k], s.ftag, s.head)) mv[k] = 1'b0;
    cyc++;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) begin mv[k] = 1'b0; mu[k] = '0; mt[k] = '0; end
    // R9: reset state
    repeat (3) @(negedge clk);
    iss_lat = 4'd1;
    #1;
    checks++;
    if (gnt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 gnt_valid=%b expected 0 in reset", gnt_valid);
    end
    checks++;
    if (iss_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 iss_ready=%b expected 1 with empty slots", iss_ready);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 18; i++) step(TBL[i]);

    // R7: flush across tag wrap, head 14: 15 and 0 are older than 1
    step('{1'b1, 4'd4, 3'd1, 4'd15, 1'b0, 4'd0, 4'd14, 1'b1});
    step('{1'b1, 4'd2, 3'd2, 4'd0,  1'b0, 4'd0, 4'd14, 1'b1});
    step('{1'b1, 4'd6, 3'd3, 4'd1,  1'b0, 4'd0, 4'd14, 1'b1});
    step('{1'b0, 4'd0, 3'd0, 4'd0,  1'b1, 4'd0, 4'd14, 1'b0});
    for (int i = 0; i < 8; i++)
      step('{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd14, 1'b0});

    // R6: a maximum-latency request right behind a flush
    step('{1'b1, 4'd8, 3'd6, 4'd9, 1'b0, 4'd0, 4'd14, 1'b1});
    for (int i = 0; i < 10; i++)
      step('{1'b0, 4'd0, 3'd0, 4'd0, 1'b0, 4'd0, 4'd14, 1'b0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule